// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A controller pulses a start strobe with an 8-bit starting column. The block then emits one column per clock, together with a valid flag and a flag that marks the final beat. The burst length and ordering come from the length code and type bit of the mode register. Both are captured when the burst is launched.

Sequential bursts count upward inside the aligned block whose size is the burst length. A full-page burst walks all 256 columns and wraps modulo 256. Interleaved bursts XOR the beat index into the low bits of the starting column. A burst can be cut short on any cycle by a terminate strobe. It can also be replaced on any cycle by a new start, or by an interrupt strobe that carries its own column. A new column command may arrive on every clock. A write-mode bit forces every write to a single beat while reads keep the programmed length.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is high, and on the first cycle after it, `valid_o` and `last_o` are 0.
- R2: Length code `len_code_i` 3'b000, 3'b001, 3'b010 and 3'b011 gives bursts of 1, 2, 4 and 8 beats.
- R3: Length code 3'b111 with sequential type (`ilv_i`=0) gives a 256-beat burst. Beat n is (S+n) mod 256, where S is the start column.
- R4: A sequential burst of length L (`ilv_i`=0) gives beat n = (S AND NOT(L-1)) OR ((S+n) AND (L-1)). The upper bits stay fixed and the low bits wrap inside the aligned block.
- R5: An interleaved burst (`ilv_i`=1) of length L gives beat n = S XOR n, for n < L.
- R6: The reserved length codes 3'b100, 3'b101 and 3'b110 give a 1-beat burst. So does code 3'b111 with interleaved type.
- R7: The first beat appears on the cycle after the start edge, with `col_o` equal to the supplied column. Commands on consecutive clocks are each accepted.
- R8: `last_o` is 1 exactly on the final beat of a burst, and `valid_o` is 0 on the cycle after it unless a new burst is loaded.
- R9: A terminate strobe during a burst makes `valid_o` 0 from the next cycle. A terminate while idle has no effect.
- R10: A start or interrupt during a burst replaces it, and the next cycle shows the new column as beat 0. When both strobe together, the interrupt's column and write flag win.
- R11: When `wr_single_i` is 1, a burst whose write flag is 1 lasts one beat and reads keep the programmed length. When `wr_single_i` is 0, writes use the programmed length.
- R12: The length code, type bit and write-mode bit are sampled only on the load edge. Changing them mid-burst does not alter the burst.
- R13: A start or interrupt arriving together with terminate loads the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a burst at `start_col_i` |
| start_col_i | input | 8 | Starting column for `start_i` |
| start_wr_i | input | 1 | 1 = the launched burst is a write |
| intr_i | input | 1 | Replace any burst with one at `intr_col_i` |
| intr_col_i | input | 8 | Starting column for `intr_i` |
| intr_wr_i | input | 1 | 1 = the interrupting burst is a write |
| term_i | input | 1 | End the current burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| wr_single_i | input | 1 | 1 = writes are single beat |
| col_o | output | 8 | Current column |
| valid_o | output | 1 | `col_o` is a live beat |
| last_o | output | 1 | Current beat is the burst's final one |

## Verification
The embedded properties assume that every strobe and every column or mode input is settled at the rising edge it is meant for. They also assume that reset is held for at least one edge before any strobe. The properties make no assumption about strobe overlap, because overlap is resolved by the priority in R10 and R13. The stimulus changes all inputs only at falling clock edges and gives every command a single full cycle. It deliberately stacks start, interrupt and terminate on the same edge to exercise that priority.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  // Burst ordering selected by the mode type bit.
  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } order_e;

  // Length field encodings.
  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code_i,
  input  order_e           order_i,
  input  logic             wr_single_i,
  input  logic             is_write_i,
  output logic [COL_W-1:0] mask_o      // burst length minus one
);
  localparam logic [COL_W-1:0] M1 = COL_W'(0);
  localparam logic [COL_W-1:0] M2 = COL_W'(1);
  localparam logic [COL_W-1:0] M4 = COL_W'(3);
  localparam logic [COL_W-1:0] M8 = COL_W'(7);
  localparam logic [COL_W-1:0] MPAGE = {COL_W{1'b1}};

  logic [COL_W-1:0] raw_mask;

  always_comb begin
    unique case (len_code_i)
      LEN_1:    raw_mask = M1;
      LEN_2:    raw_mask = M2;
      LEN_4:    raw_mask = M4;
      LEN_8:    raw_mask = M8;
      // full page is legal only for sequential ordering
      LEN_PAGE: raw_mask = (order_i == ORDER_SEQ) ? MPAGE : M1;
      default:  raw_mask = M1;  // reserved codes act as one beat
    endcase
  end

  assign mask_o = (wr_single_i && is_write_i) ? M1 : raw_mask;
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] beat_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign sum     = base_i + beat_i;
  assign seq_col = (base_i & ~mask_i) | (sum & mask_i);
  assign ilv_col = base_i ^ (beat_i & mask_i);
  assign col_o   = (order_i == ORDER_ILV) ? ilv_col : seq_col;
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [COL_W-1:0] ld_col_i,
  input  logic [COL_W-1:0] ld_mask_i,
  input  order_e           ld_order_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             busy_q, last_q;
  logic [COL_W-1:0] base_q, mask_q, beat_q, col_q;
  order_e           order_q;
  logic [COL_W-1:0] beat_nxt, col_nxt;

  assign beat_nxt = beat_q + COL_W'(1);

  burst_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i  (base_q),
    .mask_i  (mask_q),
    .beat_i  (beat_nxt),
    .order_i (order_q),
    .col_o   (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      col_q   <= '0;
      order_q <= ORDER_SEQ;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      base_q  <= ld_col_i;
      mask_q  <= ld_mask_i;
      order_q <= ld_order_i;
      beat_q  <= '0;
      col_q   <= ld_col_i;
      last_q  <= (ld_mask_i == '0);
    end else if (term_i) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (busy_q) begin
      if (last_q) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        beat_q <= beat_nxt;
        col_q  <= col_nxt;
        last_q <= (beat_nxt == mask_q);
      end
    end
  end

  assign col_o   = col_q;
  assign valid_o = busy_q;
  assign last_o  = last_q;

  // R8: the final-beat flag is only seen on a live beat
  a_r8_last_in_burst: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  // R8: nothing follows the final beat unless a new burst loads
  a_r8_ends_after_last: assert property (@(posedge clk) disable iff (rst)
    (last_o && !load_i) |=> !valid_o);

  // R9: terminate drops valid on the next cycle
  a_r9_term_drops: assert property (@(posedge clk) disable iff (rst)
    (term_i && !load_i) |=> !valid_o);

  // R7: the loaded column is beat zero
  a_r7_first_beat: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (valid_o && col_o == $past(ld_col_i)));

  // R4: sequential beats never leave the aligned block
  a_r4_block_fixed: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !load_i && !term_i && order_q == ORDER_SEQ)
      |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             start_wr_i,
  input  logic             intr_i,
  input  logic [COL_W-1:0] intr_col_i,
  input  logic             intr_wr_i,
  input  logic             term_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             load;
  logic [COL_W-1:0] ld_col;
  logic             ld_wr;
  logic [COL_W-1:0] ld_mask;
  order_e           ld_order;

  // interrupt outranks a plain start
  assign load     = start_i | intr_i;
  assign ld_col   = intr_i ? intr_col_i : start_col_i;
  assign ld_wr    = intr_i ? intr_wr_i  : start_wr_i;
  assign ld_order = ilv_i ? ORDER_ILV : ORDER_SEQ;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code_i  (len_code_i),
    .order_i     (ld_order),
    .wr_single_i (wr_single_i),
    .is_write_i  (ld_wr),
    .mask_o      (ld_mask)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .ld_col_i   (ld_col),
    .ld_mask_i  (ld_mask),
    .ld_order_i (ld_order),
    .term_i     (term_i),
    .col_o      (col_o),
    .valid_o    (valid_o),
    .last_o     (last_o)
  );
endmodule

// File: tb/sdram_burst_colgen_bench.sv
`timescale 1ns/1ps
module sdram_burst_colgen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, start_wr_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic       intr_i = 1'b0, intr_wr_i = 1'b0;
  logic [7:0] intr_col_i = '0;
  logic       term_i = 1'b0;
  logic [2:0] len_code_i = 3'b000;
  logic       ilv_i = 1'b0, wr_single_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // expected output queues (one entry per clock after each drive)
  logic       q_v[$];
  logic [7:0] q_c[$];
  logic       q_l[$];
  string      q_t[$];

  // reference state
  bit m_busy = 0;
  int m_base = 0, m_mask = 0, m_n = 0;
  bit m_ilv = 0;

  always #10 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst(rst),
    .start_i(start_i), .start_col_i(start_col_i), .start_wr_i(start_wr_i),
    .intr_i(intr_i), .intr_col_i(intr_col_i), .intr_wr_i(intr_wr_i),
    .term_i(term_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
    .wr_single_i(wr_single_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int burst_len(input logic [2:0] code, input bit ilv,
                                   input bit ws, input bit wr);
    int l;
    case (code)
      3'b000: l = 1;
      3'b001: l = 2;
      3'b010: l = 4;
      3'b011: l = 8;
      3'b111: l = ilv ? 1 : 256;
      default: l = 1;
    endcase
    if (ws && wr) l = 1;
    return l;
  endfunction

  function automatic int exp_col();
    if (m_ilv) return (m_base ^ (m_n & m_mask)) & 255;
    return ((m_base & ~m_mask) | ((m_base + m_n) & m_mask)) & 255;
  endfunction

  task automatic model_load(input logic [7:0] c, input bit wr);
    m_busy = 1;
    m_base = c;
    m_ilv  = ilv_i;
    m_mask = burst_len(len_code_i, ilv_i, wr_single_i, wr) - 1;
    m_n    = 0;
  endtask

  // apply one cycle of stimulus, predict the outputs after the next rise
  task automatic drive(input bit st, input logic [7:0] sc, input bit sw,
                       input bit it, input logic [7:0] ic, input bit iw,
                       input bit tm, input string tag);
    start_i = st; start_col_i = sc; start_wr_i = sw;
    intr_i = it; intr_col_i = ic; intr_wr_i = iw; term_i = tm;
    if (it)          model_load(ic, iw);
    else if (st)     model_load(sc, sw);
    else if (tm)     m_busy = 0;
    else if (m_busy) begin
      if (m_n == m_mask) m_busy = 0;
      else m_n++;
    end
    q_v.push_back(m_busy);
    q_c.push_back(8'(exp_col()));
    q_l.push_back(m_busy && (m_n == m_mask));
    q_t.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 8'h00, 0, 0, 8'h00, 0, 0, tag);
  endtask

  task automatic go(input logic [7:0] c, input bit wr, input string tag);
    drive(1, c, wr, 0, 8'h00, 0, 0, tag);
  endtask

  // monitor: compare 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_v.size() > 0) begin
        logic ev, el; logic [7:0] ec; string t;
        ev = q_v.pop_front(); ec = q_c.pop_front();
        el = q_l.pop_front(); t = q_t.pop_front();
        vectors++;
        if (valid_o !== ev || last_o !== el || (ev && col_o !== ec)) begin
          errors++;
          $display("FAIL %s: got valid=%b last=%b col=%02h, expected valid=%b last=%b col=%02h",
                   t, valid_o, last_o, col_o, ev, el, ec);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got valid=%b last=%b, expected 0 0", valid_o, last_o);
    end
    rst = 1'b0;
    idle(2, "R1");

    // R2 lengths with sequential order
    len_code_i = 3'b000; go(8'h35, 0, "R2"); idle(2, "R2");
    len_code_i = 3'b001; go(8'h35, 0, "R2"); idle(3, "R2");
    len_code_i = 3'b010; go(8'h35, 0, "R2"); idle(5, "R2");
    len_code_i = 3'b011; go(8'h35, 0, "R2"); idle(9, "R2");
    // R4 wrap inside aligned block
    len_code_i = 3'b011; go(8'h3E, 0, "R4"); idle(9, "R4");
    len_code_i = 3'b010; go(8'hC7, 0, "R4"); idle(5, "R4");
    // R5 interleaved
    ilv_i = 1; len_code_i = 3'b011; go(8'h35, 0, "R5"); idle(9, "R5");
    len_code_i = 3'b010; go(8'hA2, 0, "R5"); idle(5, "R5");
    // R6 reserved codes and page+interleaved
    len_code_i = 3'b111; go(8'h10, 0, "R6"); idle(2, "R6");
    ilv_i = 0;
    len_code_i = 3'b100; go(8'h11, 0, "R6"); idle(2, "R6");
    len_code_i = 3'b101; go(8'h12, 0, "R6"); idle(2, "R6");
    len_code_i = 3'b110; go(8'h13, 0, "R6"); idle(2, "R6");
    // R3 full page wrap from 0xFE
    len_code_i = 3'b111; go(8'hFE, 0, "R3"); idle(258, "R3");
    // R9 terminate mid burst, then idle terminate
    len_code_i = 3'b011; go(8'h40, 0, "R9"); idle(2, "R9");
    drive(0, 8'h00, 0, 0, 8'h00, 0, 1, "R9"); idle(2, "R9");
    drive(0, 8'h00, 0, 0, 8'h00, 0, 1, "R9"); idle(2, "R9");
    // R10 interrupt and restart mid burst, priority when both
    go(8'h50, 0, "R10"); idle(2, "R10");
    drive(0, 8'h00, 0, 1, 8'h63, 0, 0, "R10"); idle(3, "R10");
    go(8'h70, 0, "R10"); idle(9, "R10");
    wr_single_i = 1;
    drive(1, 8'h81, 0, 1, 8'h92, 1, 0, "R10"); idle(2, "R10");
    drive(1, 8'h81, 1, 1, 8'h92, 0, 0, "R10"); idle(9, "R10");
    // R11 single-beat writes
    go(8'hA0, 1, "R11"); idle(2, "R11");
    go(8'hA0, 0, "R11"); idle(9, "R11");
    wr_single_i = 0;
    go(8'hB4, 1, "R11"); idle(9, "R11");
    // R12 mode change mid burst
    go(8'hC9, 0, "R12");
    len_code_i = 3'b000; ilv_i = 1; wr_single_i = 1;
    idle(9, "R12");
    ilv_i = 0; wr_single_i = 0; len_code_i = 3'b010;
    // R13 load with terminate
    go(8'hD0, 0, "R13");
    drive(1, 8'hE5, 0, 0, 8'h00, 0, 1, "R13"); idle(1, "R13");
    drive(0, 8'h00, 0, 1, 8'hF1, 0, 1, "R13"); idle(5, "R13");
    // R7 back-to-back starts each clock
    go(8'h01, 0, "R7"); go(8'h22, 0, "R7"); go(8'h43, 0, "R7"); idle(5, "R7");

    @(posedge clk); #6;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule